// File: doc/BRIEF.md
# Vector length grant unit

This unit holds the active vector length of a vector processor and decides how many elements a strip-mined loop may process on each pass. Software issues a set-length request that carries the application vector length it still has to process. The unit compares that request with the maximum vector length that the configuration logic currently reports. It then writes the granted length into its length register and returns the same value as the scalar result of the request.

The grant is not a plain minimum. When the remaining work is more than one maximum-length strip but less than two, the unit grants half of the request, rounded up. The last two passes of the loop then carry nearly equal work, instead of one full strip followed by a short one.

A configuration write forces the length register to the maximum length. A change of one register's element type leaves the length alone. For the element datapaths, the unit decodes an element index: it reports whether that element is active, and whether it lies in the tail between the active length and the maximum length. It also flags a zero length.

Top module: `vlen_grant`

## Requirements
- R1: After reset the length register is 0, `rsp_valid` is low and `len_zero` is high.
- R2: When the requested length is at most `mvl`, the grant equals the requested length.
- R3: When the requested length is strictly greater than `mvl` and strictly less than 2·`mvl`, the grant equals (request+1)/2 rounded down, that is, half the request rounded up.
- R4: When the requested length is at least 2·`mvl`, the grant equals `mvl`. This covers an all-ones request, which returns `mvl`, and an `mvl` of 0, which grants 0 for every request.
- R5: The cycle after a request, `rsp_valid` is high for exactly one cycle and `rsp_len` carries the grant zero-extended to XLEN bits. From that cycle on, `act_len` holds the same grant.
- R6: A cycle with `cfg_wr` high loads `act_len` with the `mvl` value present in that cycle. It takes precedence over a request in the same cycle, and that request still returns its own grant on `rsp_len`.
- R7: A cycle with only `type_chg` high (no request, no configuration write) leaves `act_len` unchanged and produces no response.
- R8: `probe_tail` is high exactly when `act_len` ≤ `probe_idx` < `mvl`.
- R9: `elem_en` is high exactly when `probe_idx` < `act_len`. `len_zero` is high exactly when `act_len` is 0, so a zero length enables no element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mvl | input | MVL_W | Current maximum vector length from configuration logic |
| req_valid | input | 1 | Set-length request strobe |
| req_avl | input | XLEN | Requested (application) vector length, unsigned |
| cfg_wr | input | 1 | Configuration state was written |
| type_chg | input | 1 | Single-register element type change |
| probe_idx | input | MVL_W | Element index to classify |
| rsp_valid | output | 1 | Grant result valid |
| rsp_len | output | XLEN | Granted length returned as scalar result |
| act_len | output | MVL_W | Stored active vector length |
| probe_tail | output | 1 | Index lies in the tail region |
| elem_en | output | 1 | Index is an active element |
| len_zero | output | 1 | Active length is zero |

## Verification
The bench builds the unit with XLEN=16 and MVL_W=5, so every maximum length from 0 to 31 can be visited. For each of them, every request from 0 up to past twice the maximum is issued, along with all-ones and near-all-ones requests, so all three grant regions and both of their boundaries are covered. After each grant the whole index range is swept for the tail, enable and zero flags. The small length width also brings the disabled case (maximum 0), the same-cycle configuration-write conflict and the type-change hold within a few thousand cycles.

// File: rtl/vlen_grant.sv
module vlen_grant #(
  parameter int XLEN  = 16,
  parameter int MVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MVL_W-1:0] mvl,
  input  logic             req_valid,
  input  logic [XLEN-1:0]  req_avl,
  input  logic             cfg_wr,
  input  logic             type_chg,
  input  logic [MVL_W-1:0] probe_idx,
  output logic             rsp_valid,
  output logic [XLEN-1:0]  rsp_len,
  output logic [MVL_W-1:0] act_len,
  output logic             probe_tail,
  output logic             elem_en,
  output logic             len_zero
);

  localparam int AW = XLEN + 1;

  initial begin
    if (XLEN < MVL_W + 2) $error("XLEN must exceed MVL_W by at least 2");
  end

  logic [AW-1:0] avl_w, mvl_x, mvl_dbl, half_up, grant_w;

  assign avl_w   = {1'b0, req_avl};
  assign mvl_x   = {{(AW-MVL_W){1'b0}}, mvl};
  assign mvl_dbl = mvl_x << 1;
  assign half_up = (avl_w + AW'(1)) >> 1;

  always_comb begin
    if (avl_w <= mvl_x)        grant_w = avl_w;
    else if (avl_w < mvl_dbl)  grant_w = half_up;
    else                       grant_w = mvl_x;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_len   <= '0;
      rsp_valid <= 1'b0;
      rsp_len   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_len <= grant_w[XLEN-1:0];
      if (cfg_wr)         act_len <= mvl;
      else if (req_valid) act_len <= grant_w[MVL_W-1:0];
    end
  end

  assign elem_en    = probe_idx < act_len;
  assign probe_tail = (probe_idx >= act_len) && (probe_idx < mvl);
  assign len_zero   = act_len == '0;

  assert_grant_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> grant_w <= mvl_x);

  assert_rsp_follows_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_rsp_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_len <= XLEN'($past(mvl)));

  assert_half_covers_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && ($past(req_avl) < XLEN'({$past(mvl), 1'b0})) |->
      ({1'b0, rsp_len} << 1) >= {1'b0, $past(req_avl)});

  assert_cfg_forces_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_wr) |-> act_len == $past(mvl));

  assert_type_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(type_chg && !cfg_wr && !req_valid) |-> act_len == $past(act_len));

  assert_zero_no_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    len_zero |-> !elem_en);

  assert_tail_disjoint_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(probe_tail && elem_en));

endmodule

// File: tb/sim_vlen_grant.sv
`timescale 1ns/1ps
module sim_vlen_grant;
  localparam int XW = 16;
  localparam int MW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, req_valid, cfg_wr, type_chg;
  logic [MW-1:0] mvl, probe_idx, act_len;
  logic [XW-1:0] req_avl, rsp_len;
  logic rsp_valid, probe_tail, elem_en, len_zero;

  vlen_grant #(.XLEN(XW), .MVL_W(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .mvl(mvl), .req_valid(req_valid),
    .req_avl(req_avl), .cfg_wr(cfg_wr), .type_chg(type_chg),
    .probe_idx(probe_idx), .rsp_valid(rsp_valid), .rsp_len(rsp_len),
    .act_len(act_len), .probe_tail(probe_tail), .elem_en(elem_en),
    .len_zero(len_zero));

  int checks = 0;
  int fails  = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_grant(int m, int a);
    if (a <= m) return a;
    if (a < 2*m) return (a + 1) / 2;
    return m;
  endfunction

  task automatic sweep_idx(int m, int len);
    for (int i = 0; i < (1 << MW); i++) begin
      probe_idx = MW'(i);
      #0.1;
      chk("R8 tail", int'(probe_tail), int'(i >= len && i < m));
      chk("R9 enable", int'(elem_en), int'(i < len));
    end
    chk("R9 zero", int'(len_zero), int'(len == 0));
  endtask

  task automatic issue(int m, int a);
    int g;
    string tag;
    @(negedge clk);
    req_valid = 1'b1;
    req_avl   = XW'(a);
    @(negedge clk);
    req_valid = 1'b0;
    g = exp_grant(m, a);
    tag = (a <= m) ? "R2" : ((a < 2*m) ? "R3" : "R4");
    chk({tag, " grant"}, int'(rsp_len), g);
    chk("R5 valid", int'(rsp_valid), 1);
    chk("R5 stored", int'(act_len), g);
    sweep_idx(m, g);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; cfg_wr = 1'b0; type_chg = 1'b0;
    mvl = '0; req_avl = '0; probe_idx = '0;
    repeat (3) @(negedge clk);
    chk("R1 length", int'(act_len), 0);
    chk("R1 valid", int'(rsp_valid), 0);
    chk("R1 zero", int'(len_zero), 1);
    rst_n = 1'b1;

    for (int m = 0; m < (1 << MW); m++) begin
      @(negedge clk);
      mvl = MW'(m);
      cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
      chk("R6 cfg load", int'(act_len), m);
      chk("R5 no rsp", int'(rsp_valid), 0);
      for (int a = 0; a <= 2*m + 3; a++) issue(m, a);
      issue(m, 'hFFFF);
      issue(m, 'hFFFE);
      @(negedge clk);
      chk("R5 one cycle", int'(rsp_valid), 0);
    end

    mvl = MW'(20);
    issue(20, 30);
    @(negedge clk);
    type_chg = 1'b1;
    @(negedge clk);
    type_chg = 1'b0;
    chk("R7 hold", int'(act_len), 15);
    chk("R7 no rsp", int'(rsp_valid), 0);

    issue(20, 3);
    @(negedge clk);
    cfg_wr = 1'b1; req_valid = 1'b1; req_avl = XW'(30);
    @(negedge clk);
    cfg_wr = 1'b0; req_valid = 1'b0;
    chk("R6 priority", int'(act_len), 20);
    chk("R6 grant", int'(rsp_len), 15);
    chk("R6 valid", int'(rsp_valid), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule